// File: doc/BRIEF.md
# Dual-Clock Byte/Nibble Selectable RAM

This block holds 256 bits of storage behind one write port and one read port. Each port runs on its own clock. A static organisation input decides how the storage is seen. With the input high it is 32 words of 8 bits. With the input low it is 64 words of 4 bits. Both views share the same cells, so data written in one organisation can be read back in the other.

Each port takes a 6-bit address and its own enable. A common block enable qualifies both ports. The active clock edge of each port is fixed at elaboration by a parameter, so no clock passes through a gate.

The read side is synchronous. A qualified read captures the addressed row on the active read edge, and the result appears on the 8-bit read bus after that edge. When no qualified read occurs, the bus keeps its last value.

Top module: `split_org_ram`

## Requirements
- R1: The block stores 256 bits. `i_byte_mode`=1 selects 32 words x 8 bits. `i_byte_mode`=0 selects 64 words x 4 bits.
- R2: In byte mode, a write with `i_wr_en`=1 and `i_blk_en`=1 on the active write edge stores `i_wr_data[7:0]` in row `i_wr_addr[4:0]`. Address bit 5 is ignored on both ports.
- R3: In nibble mode, a qualified write stores `i_wr_data[3:0]` in row `addr[4:0]`. It goes to the lane chosen by `addr[5]`: 0 selects row bits 3:0 and 1 selects row bits 7:4. The other lane of that row is unchanged, and `i_wr_data[7:4]` is ignored.
- R4: In nibble mode, a qualified read returns the selected lane on `o_rd_data[3:0]`, with `o_rd_data[7:4]` = 0.
- R5: Both organisations map onto the same cells. Byte row r equals {nibble at address 32+r, nibble at address r}.
- R6: `o_rd_data` changes only after an active read edge where `i_rd_en`=1 and `i_blk_en`=1. Otherwise it holds, even if the address or mode changes.
- R7: A write with `i_wr_en`=0 or `i_blk_en`=0 leaves the memory unchanged.
- R8: A read and a write to the same row on the same active edge return the old contents. The new contents are returned by the next read.
- R9: `WR_FALLING`/`RD_FALLING` = 0 select the rising edge and 1 selects the falling edge. The other edge of that clock has no effect.
- R10: `i_rst` is synchronous to the active read edge and clears `o_rd_data` to 0. The memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_rst | input | 1 | Synchronous active-high reset of the read output, sampled on the active read edge |
| i_byte_mode | input | 1 | Organisation: 1 = 32x8, 0 = 64x4 |
| i_blk_en | input | 1 | Block enable, qualifies both ports |
| i_wr_clk | input | 1 | Write clock |
| i_wr_en | input | 1 | Write enable |
| i_wr_addr | input | ADDR_W (6) | Write address |
| i_wr_data | input | DATA_W (8) | Write data |
| i_rd_clk | input | 1 | Read clock |
| i_rd_en | input | 1 | Read enable |
| i_rd_addr | input | ADDR_W (6) | Read address |
| o_rd_data | output | DATA_W (8) | Registered read data |

## Verification
The bench builds two copies on one clock and drives them with identical stimulus. The first copy uses rising edges on both ports. The second uses falling edges on both ports.

Sampling each copy half a cycle after the other shows that each copy reacts only on its chosen edge. Running both copies also covers same-edge read-during-write in both polarities.

The default widths give 8-bit rows split into two 4-bit lanes. This makes it possible to check the cross-organisation mapping, nibble zero-extension and address-bit-5 masking, both with directed cases and with random mode switching.

// File: rtl/srm_pkg.sv
package srm_pkg;
  // number of narrow lanes that make up one wide row
  localparam int LANES = 2;

  typedef enum logic {
    ORG_NIBBLE = 1'b0,
    ORG_BYTE   = 1'b1
  } org_e;
endpackage

// File: rtl/srm_wr_ctl.sv
module srm_wr_ctl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                              i_byte_mode,
  input  logic                              i_go,
  input  logic [ADDR_W-1:0]                 i_addr,
  input  logic [DATA_W-1:0]                 i_data,
  output logic [ADDR_W-2:0]                 o_row,
  output logic [srm_pkg::LANES-1:0]         o_lane_we,
  output logic [srm_pkg::LANES-1:0][DATA_W/2-1:0] o_lane_data
);
  localparam int LANE_W = DATA_W / 2;

  assign o_row = i_addr[ADDR_W-2:0];

  for (genvar l = 0; l < srm_pkg::LANES; l++) begin : g_lane
    // byte mode: every lane written from its own slice
    // nibble mode: only the lane picked by the top address bit, fed from the low slice
    assign o_lane_we[l]   = i_go & (i_byte_mode | (i_addr[ADDR_W-1] == 1'(l)));
    assign o_lane_data[l] = i_byte_mode ? i_data[l*LANE_W +: LANE_W] : i_data[LANE_W-1:0];
  end
endmodule

// File: rtl/srm_core.sv
module srm_core #(
  parameter int LANE_W     = 4,
  parameter int ROW_AW     = 5,
  parameter bit WR_FALLING = 1'b0,
  parameter bit RD_FALLING = 1'b0
) (
  input  logic                                   i_wr_clk,
  input  logic [srm_pkg::LANES-1:0]              i_lane_we,
  input  logic [ROW_AW-1:0]                      i_wr_row,
  input  logic [srm_pkg::LANES-1:0][LANE_W-1:0]  i_lane_data,
  input  logic                                   i_rd_clk,
  input  logic                                   i_rst,
  input  logic                                   i_rd_cap,
  input  logic [ROW_AW-1:0]                      i_rd_row,
  output logic [srm_pkg::LANES-1:0][LANE_W-1:0]  o_word
);
  localparam int ROWS = 1 << ROW_AW;

  for (genvar l = 0; l < srm_pkg::LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [ROWS];
    logic [LANE_W-1:0] rd_q;

    if (WR_FALLING) begin : g_wr_neg
      always_ff @(negedge i_wr_clk) begin
        if (i_lane_we[l]) mem[i_wr_row] <= i_lane_data[l];
      end
    end else begin : g_wr_pos
      always_ff @(posedge i_wr_clk) begin
        if (i_lane_we[l]) mem[i_wr_row] <= i_lane_data[l];
      end
    end

    if (RD_FALLING) begin : g_rd_neg
      always_ff @(negedge i_rd_clk) begin
        if (i_rst)         rd_q <= '0;
        else if (i_rd_cap) rd_q <= mem[i_rd_row];
      end
    end else begin : g_rd_pos
      always_ff @(posedge i_rd_clk) begin
        if (i_rst)         rd_q <= '0;
        else if (i_rd_cap) rd_q <= mem[i_rd_row];
      end
    end

    assign o_word[l] = rd_q;
  end
endmodule

// File: rtl/srm_rd_fmt.sv
module srm_rd_fmt #(
  parameter int LANE_W     = 4,
  parameter bit RD_FALLING = 1'b0
) (
  input  logic                                  i_clk,
  input  logic                                  i_rst,
  input  logic                                  i_cap,
  input  logic                                  i_byte_mode,
  input  logic                                  i_lane_sel,
  input  logic [srm_pkg::LANES-1:0][LANE_W-1:0] i_word,
  output logic [srm_pkg::LANES*LANE_W-1:0]      o_data
);
  import srm_pkg::*;
  localparam int DW = LANES * LANE_W;

  org_e mode_q, mode_d;
  logic lane_q, lane_d;

  always_comb begin
    mode_d = mode_q;
    lane_d = lane_q;
    if (i_rst) begin
      mode_d = ORG_BYTE;
      lane_d = 1'b0;
    end else if (i_cap) begin
      mode_d = org_e'(i_byte_mode);
      lane_d = i_lane_sel;
    end
  end

  if (RD_FALLING) begin : g_neg
    always_ff @(negedge i_clk) begin
      mode_q <= mode_d;
      lane_q <= lane_d;
    end

    AST_RD_HOLD: assert property (@(negedge i_clk) disable iff (i_rst)
      !i_cap |=> $stable(o_data)); // R6
    AST_NIBBLE_UPPER_ZERO: assert property (@(negedge i_clk) disable iff (i_rst)
      (i_cap && !i_byte_mode) |=> (o_data[DW-1:LANE_W] == '0)); // R4
    AST_RESET_CLEARS: assert property (@(negedge i_clk)
      i_rst |=> (o_data == '0)); // R10
  end else begin : g_pos
    always_ff @(posedge i_clk) begin
      mode_q <= mode_d;
      lane_q <= lane_d;
    end

    AST_RD_HOLD: assert property (@(posedge i_clk) disable iff (i_rst)
      !i_cap |=> $stable(o_data)); // R6
    AST_NIBBLE_UPPER_ZERO: assert property (@(posedge i_clk) disable iff (i_rst)
      (i_cap && !i_byte_mode) |=> (o_data[DW-1:LANE_W] == '0)); // R4
    AST_RESET_CLEARS: assert property (@(posedge i_clk)
      i_rst |=> (o_data == '0)); // R10
  end

  always_comb begin
    if (mode_q == ORG_BYTE) o_data = i_word;
    else                    o_data = {{(DW-LANE_W){1'b0}}, i_word[lane_q]};
  end
endmodule

// File: rtl/split_org_ram.sv
module split_org_ram #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter bit WR_FALLING = 1'b0,
  parameter bit RD_FALLING = 1'b0
) (
  input  logic              i_rst,
  input  logic              i_byte_mode,
  input  logic              i_blk_en,
  input  logic              i_wr_clk,
  input  logic              i_wr_en,
  input  logic [ADDR_W-1:0] i_wr_addr,
  input  logic [DATA_W-1:0] i_wr_data,
  input  logic              i_rd_clk,
  input  logic              i_rd_en,
  input  logic [ADDR_W-1:0] i_rd_addr,
  output logic [DATA_W-1:0] o_rd_data
);
  localparam int LANE_W = DATA_W / 2;
  localparam int ROW_AW = ADDR_W - 1;

  logic                                  wr_go;
  logic                                  rd_cap;
  logic [ROW_AW-1:0]                     wr_row;
  logic [srm_pkg::LANES-1:0]             lane_we;
  logic [srm_pkg::LANES-1:0][LANE_W-1:0] lane_data;
  logic [srm_pkg::LANES-1:0][LANE_W-1:0] rd_word;

  assign wr_go  = i_wr_en & i_blk_en;
  assign rd_cap = i_rd_en & i_blk_en;

  srm_wr_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr_ctl (
    .i_byte_mode (i_byte_mode),
    .i_go        (wr_go),
    .i_addr      (i_wr_addr),
    .i_data      (i_wr_data),
    .o_row       (wr_row),
    .o_lane_we   (lane_we),
    .o_lane_data (lane_data)
  );

  srm_core #(
    .LANE_W(LANE_W), .ROW_AW(ROW_AW),
    .WR_FALLING(WR_FALLING), .RD_FALLING(RD_FALLING)
  ) u_core (
    .i_wr_clk    (i_wr_clk),
    .i_lane_we   (lane_we),
    .i_wr_row    (wr_row),
    .i_lane_data (lane_data),
    .i_rd_clk    (i_rd_clk),
    .i_rst       (i_rst),
    .i_rd_cap    (rd_cap),
    .i_rd_row    (i_rd_addr[ROW_AW-1:0]),
    .o_word      (rd_word)
  );

  srm_rd_fmt #(.LANE_W(LANE_W), .RD_FALLING(RD_FALLING)) u_rd_fmt (
    .i_clk       (i_rd_clk),
    .i_rst       (i_rst),
    .i_cap       (rd_cap),
    .i_byte_mode (i_byte_mode),
    .i_lane_sel  (i_rd_addr[ADDR_W-1]),
    .i_word      (rd_word),
    .o_data      (o_rd_data)
  );

  always_comb begin
    AST_GATED_NO_WRITE: assert (wr_go || (lane_we == '0)); // R7
    if (!i_byte_mode) begin
      AST_NIBBLE_ONE_LANE: assert ($onehot0(lane_we)); // R3
    end else begin
      AST_BYTE_BOTH_LANES: assert ($countones(lane_we) != 1); // R2
    end
  end
endmodule

// File: tb/test_split_org_ram.sv
`timescale 1ns/1ps
module test_split_org_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_mode = 1'b1;
  logic       blk_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [7:0] out_r;
  logic [7:0] out_f;

  always #2.5 clk = ~clk;

  split_org_ram i_split_org_ram (
    .i_rst(rst), .i_byte_mode(byte_mode), .i_blk_en(blk_en),
    .i_wr_clk(clk), .i_wr_en(wr_en), .i_wr_addr(wr_addr), .i_wr_data(wr_data),
    .i_rd_clk(clk), .i_rd_en(rd_en), .i_rd_addr(rd_addr), .o_rd_data(out_r)
  );

  split_org_ram #(.WR_FALLING(1'b1), .RD_FALLING(1'b1)) i_split_org_ram_fall (
    .i_rst(rst), .i_byte_mode(byte_mode), .i_blk_en(blk_en),
    .i_wr_clk(clk), .i_wr_en(wr_en), .i_wr_addr(wr_addr), .i_wr_data(wr_data),
    .i_rd_clk(clk), .i_rd_en(rd_en), .i_rd_addr(rd_addr), .o_rd_data(out_f)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] ref_mem [32];
  logic [7:0] exp_q    = 8'h00;
  logic [7:0] exp_prev = 8'h00;

  function automatic logic [7:0] ref_read(input logic m, input logic [5:0] a);
    logic [7:0] row = ref_mem[a[4:0]];
    if (m) return row;
    return {4'h0, a[5] ? row[7:4] : row[3:0]};
  endfunction

  task automatic ref_write(input logic m, input logic [5:0] a, input logic [7:0] d);
    if (m)         ref_mem[a[4:0]]      = d;
    else if (a[5]) ref_mem[a[4:0]][7:4] = d[3:0];
    else           ref_mem[a[4:0]][3:0] = d[3:0];
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // entered at posedge+1.25ns, leaves at the next posedge+1.25ns
  task automatic step(input logic r, input logic b, input logic m,
                      input logic we, input logic [5:0] wa, input logic [7:0] wd,
                      input logic re, input logic [5:0] ra, input string tag);
    rst = r; blk_en = b; byte_mode = m;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    exp_prev = exp_q;
    if (r)              exp_q = 8'h00;
    else if (re && b)   exp_q = ref_read(m, ra);   // old data before this write (R8)
    if (we && b) ref_write(m, wa, wd);
    #2.5;
    chk(out_f, exp_q, {tag, " falling copy"});
    chk(out_r, exp_prev, "R9 rising copy ignores falling edge");
    #2.5;
    chk(out_r, exp_q, {tag, " rising copy"});
    chk(out_f, exp_q, "R9 falling copy ignores rising edge");
  endtask

  initial begin
    @(posedge clk); #1.25;
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R10 reset state");
    step(0, 1, 1, 0, 0, 0, 0, 0, "R10 after reset");
    for (int r = 0; r < 32; r++) step(0, 1, 1, 1, 6'(r), 8'(r*37+5), 0, 0, "R1 fill");
    // R2 byte mode, address bit 5 ignored
    step(0, 1, 1, 1, 6'd37, 8'hA5, 0, 0, "R2 write");
    step(0, 1, 1, 0, 0, 0, 1, 6'd5,  "R2 read low alias");
    step(0, 1, 1, 0, 0, 0, 1, 6'd37, "R2 read high alias");
    // R3 / R5 nibble lanes
    step(0, 1, 0, 1, 6'd3,  8'hF7, 0, 0, "R3 low lane write");
    step(0, 1, 0, 1, 6'd35, 8'hE9, 0, 0, "R3 high lane write");
    step(0, 1, 1, 0, 0, 0, 1, 6'd3,  "R5 byte view of lanes");
    step(0, 1, 0, 0, 0, 0, 1, 6'd35, "R4 high lane read");
    step(0, 1, 0, 0, 0, 0, 1, 6'd3,  "R4 low lane read");
    // R7 gated writes
    step(0, 0, 1, 1, 6'd3, 8'h00, 0, 0, "R7 write with block disabled");
    step(0, 1, 1, 0, 6'd3, 8'h11, 1, 6'd3, "R7 unchanged row");
    // R6 hold
    step(0, 0, 0, 0, 0, 0, 1, 6'd40, "R6 read with block disabled");
    step(0, 1, 0, 0, 0, 0, 0, 6'd33, "R6 hold without read enable");
    // R8 same-edge read during write
    step(0, 1, 1, 1, 6'd10, 8'h5A, 1, 6'd10, "R8 old data");
    step(0, 1, 1, 0, 0, 0, 1, 6'd10, "R8 new data next read");
    // R10 reset keeps contents
    step(1, 1, 1, 0, 0, 0, 1, 6'd10, "R10 reset clears output");
    step(0, 1, 1, 0, 0, 0, 1, 6'd5,  "R10 memory kept");
    // random traffic
    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      logic b, m, we, re;
      b  = ($urandom % 8) != 0;
      m  = $urandom % 2;
      we = ($urandom % 5) < 3;
      re = ($urandom % 4) != 0;
      step(0, b, m, we, 6'($urandom), 8'($urandom), re, 6'($urandom), "R1 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule